// File: doc/BRIEF.md
# Dual-Channel Parallel DAC Write Sequencer

This block turns single-cycle write requests into correctly timed bus cycles for a dual 8-bit multiplying converter. The converter has two code latches that share one parallel data bus. A channel-select line chooses the latch, and the latch is written through an active-low chip-select and an active-low write strobe. While both strobes are low, the chosen latch is transparent. It keeps whatever was on the bus when the first of the two strobes returns high.

A client offers a channel bit and a code through a valid/ready handshake. The sequencer then drives the bus in a fixed order:

1. It drives the select line and the code.
2. It lowers chip select.
3. It lowers write.
4. It raises write.
5. It raises chip select.

Each phase lasts a parameterised number of clock cycles, so the converter's setup, pulse-width and hold minimums can be met at any clock rate. Select and code stay steady through the closing edge of every write. The sequencer also keeps a shadow copy of the last code committed to each channel, and offers both copies as read-only outputs.

Top module: `dac_load_seq`

## Requirements
- R1: After reset, dacCsN and dacWrN are 1, reqReady is 1, and shadowA and shadowB are 0.
- R2: reqReady is 1 only while the sequencer is idle. A request is taken on a clock edge where reqValid and reqReady are both 1. From that edge, reqReady stays 0 for exactly 2*SETUP_CYC + PULSE_CYC + 2*HOLD_CYC cycles.
- R3: dacSel = 0 addresses channel A and dacSel = 1 addresses channel B. dacBus carries the requested code bit for bit, with bit 7 as the MSB. Both values appear in the first cycle after the accepting edge.
- R4: Select and code are driven for SETUP_CYC cycles with chip select high. Chip select then falls, and it is low for SETUP_CYC cycles before write falls.
- R5: dacWrN is low for exactly PULSE_CYC cycles per request, and only while dacCsN is low.
- R6: After write rises, chip select stays low for HOLD_CYC cycles and then stays high for HOLD_CYC more cycles before the sequencer is idle. dacSel and dacBus do not change from the first setup cycle to the end of that second hold phase.
- R7: On the clock edge where write rises, the shadow output of the addressed channel takes the code. The other shadow output keeps its value. Both external latches then hold the requested codes.
- R8: Between any two write sequences, chip select is high for at least one cycle.
- R9: reqValid while reqReady is 0 is ignored. It starts no write and changes neither the bus nor the shadows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqChan | input | 1 | Target channel: 0 = A, 1 = B |
| reqCode | input | 8 | Code to write |
| reqReady | output | 1 | Sequencer idle, able to take a request |
| dacCsN | output | 1 | Active-low chip select to the converter |
| dacWrN | output | 1 | Active-low write strobe to the converter |
| dacSel | output | 1 | Latch select line: 0 = A, 1 = B |
| dacBus | output | 8 | Shared data bus |
| shadowA | output | 8 | Last code committed to channel A |
| shadowB | output | 8 | Last code committed to channel B |

## Verification
All output timing is counted from the clock edge that accepts a request. Select and bus are valid in cycle 0. Chip select falls at cycle SETUP_CYC, and write is low from cycle 2*SETUP_CYC for PULSE_CYC cycles. The shadow update and the rise of write happen on the same edge. Chip select rises HOLD_CYC cycles after write, and reqReady returns HOLD_CYC cycles after that. The bench samples every output at each falling clock edge of the sequence. It compares each sample with the level expected for that cycle index, so a sequence that is off by one cycle shows up in the exact cycle where it goes wrong. A level-sensitive model of the two latches, fed from the output pins, confirms which codes the converter actually ends up holding.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CSON,
    ST_WRON,
    ST_WROFF,
    ST_CSOFF
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture; // latch request into the bus registers
    logic csLow;   // chip select asserted this cycle
    logic wrLow;   // write asserted this cycle
    logic commit;  // write rises at the coming edge: update shadow
  } seqStrobe_t;

endpackage

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output logic       reqReady,
  output seqStrobe_t strb
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_LEN = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             phaseDone;

  assign phaseDone = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = phaseDone ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext = ST_SETUP;
          cntNext   = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (phaseDone) begin
          stateNext = ST_CSON;
          cntNext   = LD_SETUP;
        end
      end
      ST_CSON: begin
        if (phaseDone) begin
          stateNext = ST_WRON;
          cntNext   = LD_PULSE;
        end
      end
      ST_WRON: begin
        if (phaseDone) begin
          stateNext = ST_WROFF;
          cntNext   = LD_HOLD;
        end
      end
      ST_WROFF: begin
        if (phaseDone) begin
          stateNext = ST_CSOFF;
          cntNext   = LD_HOLD;
        end
      end
      ST_CSOFF: begin
        if (phaseDone) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign strb.capture = (state == ST_IDLE) && reqValid;
  assign strb.csLow   = (state == ST_CSON) || (state == ST_WRON) || (state == ST_WROFF);
  assign strb.wrLow   = (state == ST_WRON);
  assign strb.commit  = (state == ST_WRON) && phaseDone;

endmodule

// File: rtl/dac_load_dpath.sv
module dac_load_dpath
  import dac_load_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  seqStrobe_t                    strb,
  input  logic                          reqChan,
  input  logic [CODE_W-1:0]             reqCode,
  output logic                          dacCsN,
  output logic                          dacWrN,
  output logic                          dacSel,
  output logic [CODE_W-1:0]             dacBus,
  output logic [NUM_CH-1:0][CODE_W-1:0] shadow
);

  logic              selQ;
  logic [CODE_W-1:0] busQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ <= 1'b0;
      busQ <= '0;
    end else if (strb.capture) begin
      selQ <= reqChan;
      busQ <= reqCode;
    end
  end

  assign dacSel = selQ;
  assign dacBus = busQ;
  assign dacCsN = ~strb.csLow;
  assign dacWrN = ~strb.wrLow;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[ch] <= '0;
      end else if (strb.commit && (int'(selQ) == ch)) begin
        shadow[ch] <= busQ;
      end
    end
  end

endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq
  import dac_load_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqChan,
  input  logic [CODE_W-1:0] reqCode,
  output logic              reqReady,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic              dacSel,
  output logic [CODE_W-1:0] dacBus,
  output logic [CODE_W-1:0] shadowA,
  output logic [CODE_W-1:0] shadowB
);

  localparam int NUM_CH = 2;

  seqStrobe_t                    strb;
  logic [NUM_CH-1:0][CODE_W-1:0] shadow;

  dac_load_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strb    (strb)
  );

  dac_load_dpath #(
    .CODE_W(CODE_W),
    .NUM_CH(NUM_CH)
  ) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .reqChan(reqChan),
    .reqCode(reqCode),
    .dacCsN (dacCsN),
    .dacWrN (dacWrN),
    .dacSel (dacSel),
    .dacBus (dacBus),
    .shadow (shadow)
  );

  assign shadowA = shadow[0];
  assign shadowB = shadow[1];

endmodule

// File: rtl/dac_load_chk.sv
module dac_load_chk #(
  parameter int CODE_W    = 8,
  parameter int PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqReady,
  input logic              dacCsN,
  input logic              dacWrN,
  input logic              dacSel,
  input logic [CODE_W-1:0] dacBus,
  input logic [CODE_W-1:0] shadowA,
  input logic [CODE_W-1:0] shadowB
);

  logic [15:0] wrLowCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wrLowCnt <= '0;
    else if (!dacWrN) wrLowCnt <= (wrLowCnt == 16'hFFFF) ? wrLowCnt : wrLowCnt + 16'd1;
    else              wrLowCnt <= '0;
  end

  AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !dacWrN |-> !dacCsN); // R5

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dacWrN) |-> (wrLowCnt == 16'(PULSE_CYC))); // R5

  AST_BUS_STABLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !dacCsN |=> ($stable(dacSel) && $stable(dacBus))); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !dacCsN |-> !reqReady); // R2

  AST_SHADOW_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(dacWrN) |-> ($stable(shadowA) && $stable(shadowB))); // R7

  AST_SHADOW_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dacWrN) |-> (dacSel ? (shadowB == dacBus) : (shadowA == dacBus))); // R7

endmodule

bind dac_load_seq dac_load_chk #(
  .CODE_W   (CODE_W),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reqReady(reqReady),
  .dacCsN  (dacCsN),
  .dacWrN  (dacWrN),
  .dacSel  (dacSel),
  .dacBus  (dacBus),
  .shadowA (shadowA),
  .shadowB (shadowB)
);

// File: tb/dac_load_seq_test.sv
module dac_load_seq_test;

  localparam int S = 2;
  localparam int P = 3;
  localparam int H = 2;
  localparam int N = 2 * S + P + 2 * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqChan = 1'b0;
  logic [7:0] reqCode = 8'h00;
  logic       reqReady, dacCsN, dacWrN, dacSel;
  logic [7:0] dacBus, shadowA, shadowB;

  int checks = 0;
  int failures = 0;
  logic [7:0] expA = 8'h00;
  logic [7:0] expB = 8'h00;
  logic [7:0] latA = 8'h00;
  logic [7:0] latB = 8'h00;
  int wrCount = 0;

  always #4 clk = ~clk;

  dac_load_seq #(.CODE_W(8), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqChan(reqChan), .reqCode(reqCode),
    .reqReady(reqReady), .dacCsN(dacCsN), .dacWrN(dacWrN), .dacSel(dacSel), .dacBus(dacBus),
    .shadowA(shadowA), .shadowB(shadowB)
  );

  // level-sensitive model of the two converter latches
  always @(dacCsN or dacWrN or dacSel or dacBus) begin
    if (!dacCsN && !dacWrN) begin
      if (dacSel) latB = dacBus;
      else        latA = dacBus;
    end
  end

  // pin-level timing monitor, sampled away from the active edge
  logic prevWrN = 1'b1;
  logic prevCsN = 1'b1;
  int   wrLowRun = 0;
  int   csHighRun = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!dacWrN) wrLowRun++;
      if (dacWrN && !prevWrN) begin
        wrCount++;
        checks++;
        if (wrLowRun != P) begin
          failures++;
          $display("FAIL R5 write low cycles actual=%0d expected=%0d", wrLowRun, P);
        end
        wrLowRun = 0;
      end
      if (!dacCsN && prevCsN) begin
        checks++;
        if (csHighRun < 1) begin
          failures++;
          $display("FAIL R8 chip-select high gap actual=%0d expected>=1", csHighRun);
        end
      end
      csHighRun = dacCsN ? csHighRun + 1 : 0;
      prevWrN = dacWrN;
      prevCsN = dacCsN;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expCsN(input int c);
    return !((c >= S) && (c < 2 * S + P + H));
  endfunction

  function automatic logic expWrN(input int c);
    return !((c >= 2 * S) && (c < 2 * S + P));
  endfunction

  // one full write; junk = drive a competing request while busy (R9)
  task automatic doWrite(input logic ch, input logic [7:0] code, input bit junk);
    int wrBefore;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    wrBefore = wrCount;
    reqValid = 1'b1;
    reqChan  = ch;
    reqCode  = code;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      reqChan = ~ch;
      reqCode = ~code;
    end else begin
      reqValid = 1'b0;
    end
    for (int k = 1; k <= N; k++) begin
      int c;
      c = k - 1;
      check("R2 ready during sequence", int'(reqReady), 0);
      check("R3 select line", int'(dacSel), int'(ch));
      check("R3/R6 data bus", int'(dacBus), int'(code));
      check("R4/R6 chip select level", int'(dacCsN), int'(expCsN(c)));
      check("R5 write level", int'(dacWrN), int'(expWrN(c)));
      if (c == 2 * S + P) begin
        check("R7 shadowA at write rise", int'(shadowA), int'(ch ? expA : code));
        check("R7 shadowB at write rise", int'(shadowB), int'(ch ? code : expB));
      end
      if (k == N) reqValid = 1'b0;
      if (k < N) @(negedge clk);
    end
    if (ch) expB = code; else expA = code;
    @(negedge clk);
    check("R2 ready after sequence", int'(reqReady), 1);
    check("R7 shadowA", int'(shadowA), int'(expA));
    check("R7 shadowB", int'(shadowB), int'(expB));
    check("R7 latch A model", int'(latA), int'(expA));
    check("R7 latch B model", int'(latB), int'(expB));
    check("R9 one write per request", wrCount - wrBefore, 1);
    if (junk) begin
      check("R9 bus untouched by busy request", int'(dacBus), int'(code));
      check("R9 chip select idle", int'(dacCsN), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    #1;
    check("R1 csN in reset", int'(dacCsN), 1);
    check("R1 wrN in reset", int'(dacWrN), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(reqReady), 1);
    check("R1 shadowA reset", int'(shadowA), 0);
    check("R1 shadowB reset", int'(shadowB), 0);
    check("R1 csN after reset", int'(dacCsN), 1);
    check("R1 wrN after reset", int'(dacWrN), 1);

    // directed corners
    doWrite(1'b0, 8'hFF, 1'b0);
    doWrite(1'b1, 8'h80, 1'b0);   // back-to-back, other channel (R8)
    doWrite(1'b1, 8'h01, 1'b1);   // busy request ignored (R9)
    doWrite(1'b0, 8'h00, 1'b0);
    doWrite(1'b0, 8'h7F, 1'b1);   // same channel back-to-back

    // random traffic
    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = int'($urandom % 4);
      repeat (gap) @(negedge clk);
      doWrite(1'(($urandom >> 3) & 1), 8'($urandom), ($urandom % 5) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule